// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Sequencer

This block sits behind the serial-bus slave of a 512 x 8 non-volatile store made of 32 pages of 16 bytes. When the bus front end has decoded a write command and its memory address, the block opens a page latch. The latch records the page number and the starting byte slot. Every data byte the front end receives and acknowledges is placed into the latch at the current slot, and the slot then advances by one, wrapping inside the same page. A mask records which slots have been filled.

The block decides at the bus STOP whether the write is committed. It commits only when at least one data byte has arrived and exactly one rising serial-clock edge has occurred since the last data byte was acknowledged, which means the STOP falls in the clock that follows the acknowledge. A write-protect input that is high at the STOP blocks the commit for the whole array. A committed write raises `busy` for a fixed number of system clocks, set by a parameter. During the first 16 of those clocks the block scans the latch and writes only the filled slots into the array. While `busy` is high the front end must not acknowledge anything, and the block itself ignores all of its command inputs.

The state machine has four states. ST_IDLE waits for a command and goes to ST_FILL when `wr_open` pulses. ST_FILL collects bytes. A new `wr_open` in ST_FILL reloads the latch and stays in ST_FILL. A committing STOP moves ST_FILL to ST_PROG. A non-committing STOP or a bus START returns ST_FILL to ST_IDLE and discards the latch. ST_PROG scans the 16 slots and goes to ST_HOLD after the last slot. ST_HOLD waits out the rest of the write cycle and returns to ST_IDLE.

Top module: `page_write_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it goes low, `busy` and `arr_we` are 0. A reset during ST_FILL discards the latch, so a later STOP commits nothing. A reset during a write cycle drops `busy` at once.
- R2: A `wr_open` pulse takes the page from `wr_addr[8:4]` and the starting slot from `wr_addr[3:0]`, and clears the fill mask.
- R3: Each `rx_valid` pulse in ST_FILL stores `rx_data` at the current slot, marks that slot as filled and advances the slot by one modulo 16. More than 16 bytes therefore overwrite earlier slots of the same page, and the last byte sent to a slot wins.
- R4: A `bus_stop` pulse in ST_FILL commits the write when at least one byte was stored, exactly one `scl_rise` pulse has occurred since the last `rx_valid`, and `wp` is 0.
- R5: A `bus_stop` with zero data bytes, or with zero or two or more `scl_rise` pulses since the last byte, or a `bus_start` pulse in ST_FILL, discards the latch. No array write follows and `busy` stays 0.
- R6: When `wp` is 1 at the STOP, no array location is written and `busy` stays 0.
- R7: `busy` rises in the cycle after a committing STOP and stays high for exactly WRITE_CLKS cycles.
- R8: In busy cycle k, for k from 0 to 15, `arr_we` is 1 exactly when slot k was filled, with `arr_addr` = {page, k} and `arr_wdata` set to the stored byte. No other array write occurs, so unfilled slots keep their old contents.
- R9: While `busy` is 1, `wr_open`, `rx_valid`, `scl_rise`, `bus_stop`, `bus_start` and `wp` have no effect: the write cycle length and the array contents are unchanged, and no new cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on stand-in) |
| wr_open | input | 1 | Pulse: write command with memory address decoded |
| wr_addr | input | 9 | Starting memory address of the write |
| rx_valid | input | 1 | Pulse: data byte received and acknowledged |
| rx_data | input | 8 | Received data byte |
| scl_rise | input | 1 | Pulse: rising edge of the serial clock |
| bus_start | input | 1 | Pulse: START condition detected |
| bus_stop | input | 1 | Pulse: STOP condition detected |
| wp | input | 1 | Write protect; high blocks every write |
| busy | output | 1 | Write cycle in progress; the bus front end must stay silent |
| arr_we | output | 1 | Array byte write enable |
| arr_addr | output | 9 | Array byte address |
| arr_wdata | output | 8 | Array byte data |

## Verification
The bench aims at the STOP-timing window. It ends commands with zero, one and three serial-clock edges after the last acknowledge, and with a START instead of a STOP. A design that counts the window wrong would either program discarded data or drop a legal write, and either error shows up as a mismatch in the array. Writes of more than 16 bytes from a slot near the end of a page test the wrap: a design that carries into the page number would write to the next page. Commands with write protect set, command traffic injected during a write cycle, and resets taken in the middle of a fill and in the middle of a cycle would expose a lost protect check, a restarted or lengthened cycle, or a stale commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_PROG,
        ST_HOLD
    } seq_state_t;

endpackage

// File: rtl/pwb_page_latch.sv
// Holds one page worth of received bytes plus a fill mask and the running slot.
module pwb_page_latch #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [$clog2(PAGE_BYTES)-1:0] load_idx,
    input  logic                          push,
    input  logic [DATA_W-1:0]             push_data,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_valid
);
    localparam int IDX_W = $clog2(PAGE_BYTES);

    logic [IDX_W-1:0]      idx_q;
    logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_used;

    // running slot pointer, wraps inside the page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= load_idx;
        end else if (push) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        logic              v_q;
        logic              hit;

        assign hit = push && (idx_q == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (load) begin
                v_q <= 1'b0;
            end else if (hit) begin
                d_q <= push_data;
                v_q <= 1'b1;
            end
        end

        assign slot_data[g] = d_q;
        assign slot_used[g] = v_q;
    end

    assign rd_data  = slot_data[rd_idx];
    assign rd_valid = slot_used[rd_idx];

endmodule

// File: rtl/pwb_stop_gate.sv
// Tracks serial-clock edges since the last acknowledged data byte.
module pwb_stop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic byte_evt,
    input  logic clk_rise,
    output logic window_ok
);
    logic       seen_q;
    logic [1:0] rises_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            rises_q <= '0;
        end else if (clr) begin
            seen_q  <= 1'b0;
            rises_q <= '0;
        end else if (byte_evt) begin
            seen_q  <= 1'b1;
            rises_q <= '0;
        end else if (clk_rise && rises_q != 2'd2) begin
            rises_q <= rises_q + 2'd1;
        end
    end

    assign window_ok = seen_q && (rises_q == 2'd1);

endmodule

// File: rtl/pwb_cycle_timer.sv
// Counts system clocks of the internal write cycle; the low bits drive the slot scan.
module pwb_cycle_timer #(
    parameter int WRITE_CLKS = 2_000_000,
    parameter int PAGE_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          run,
    output logic [$clog2(PAGE_BYTES)-1:0] slot_idx,
    output logic                          scan_last,
    output logic                          cycle_last
);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(WRITE_CLKS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot_idx   = cnt_q[IDX_W-1:0];
    assign scan_last  = (cnt_q == CNT_W'(PAGE_BYTES - 1));
    assign cycle_last = (cnt_q == CNT_W'(WRITE_CLKS - 1));

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WRITE_CLKS = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_open,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              scl_rise,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              wp,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    import pwb_pkg::*;

    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - IDX_W;

    seq_state_t        state_q, state_d;
    logic [PAGE_W-1:0] page_q;

    logic              lat_load, lat_push;
    logic [DATA_W-1:0] lat_data;
    logic              lat_valid;
    logic              gate_ok, gate_rise;
    logic              commit;
    logic              tmr_run;
    logic [IDX_W-1:0]  scan_idx;
    logic              scan_last, cycle_last;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (lat_load) begin
            page_q <= wr_addr[ADDR_W-1:IDX_W];
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_open) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (bus_stop)       state_d = commit ? ST_PROG : ST_IDLE;
                else if (bus_start) state_d = ST_IDLE;
            end
            ST_PROG: begin
                if (scan_last) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cycle_last) state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- outputs and datapath controls ----------------
    always_comb begin
        lat_load  = 1'b0;
        lat_push  = 1'b0;
        gate_rise = 1'b0;
        commit    = 1'b0;
        tmr_run   = 1'b0;
        busy      = 1'b0;
        arr_we    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                lat_load = wr_open;
            end
            ST_FILL: begin
                commit    = gate_ok && !wp;
                lat_load  = wr_open && !bus_stop && !bus_start;
                lat_push  = rx_valid && !wr_open && !bus_stop && !bus_start;
                gate_rise = scl_rise;
            end
            ST_PROG: begin
                busy    = 1'b1;
                tmr_run = 1'b1;
                arr_we  = lat_valid;
            end
            ST_HOLD: begin
                busy    = 1'b1;
                tmr_run = 1'b1;
            end
        endcase
    end

    assign arr_addr  = {page_q, scan_idx};
    assign arr_wdata = lat_data;

    // ---------------- sub-blocks ----------------
    pwb_page_latch #(
        .DATA_W    (DATA_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_idx (wr_addr[IDX_W-1:0]),
        .push     (lat_push),
        .push_data(rx_data),
        .rd_idx   (scan_idx),
        .rd_data  (lat_data),
        .rd_valid (lat_valid)
    );

    pwb_stop_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (lat_load),
        .byte_evt (lat_push),
        .clk_rise (gate_rise),
        .window_ok(gate_ok)
    );

    pwb_cycle_timer #(
        .WRITE_CLKS(WRITE_CLKS),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == ST_FILL && bus_stop && commit),
        .run       (tmr_run),
        .slot_idx  (scan_idx),
        .scan_last (scan_last),
        .cycle_last(cycle_last)
    );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int PAGE_W     = 5,
    parameter int WRITE_CLKS = 2_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp,
    input logic              bus_stop,
    input logic              busy,
    input logic              arr_we,
    input logic [PAGE_W-1:0] arr_page
);
    localparam int CNT_W = $clog2(WRITE_CLKS + 2);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    // R7
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop));

    // R6
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && wp && !busy) |=> !busy);

    // R8
    we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R8
    one_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> arr_page == $past(arr_page));

    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_cnt < CNT_W'(WRITE_CLKS));

    // R7
    busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_cnt == CNT_W'(WRITE_CLKS));

endmodule

bind page_write_seq pwb_checker #(
    .PAGE_W    (ADDR_W - $clog2(PAGE_BYTES)),
    .WRITE_CLKS(WRITE_CLKS)
) u_pwb_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp      (wp),
    .bus_stop(bus_stop),
    .busy    (busy),
    .arr_we  (arr_we),
    .arr_page(arr_addr[ADDR_W-1:$clog2(PAGE_BYTES)])
);

// File: tb/page_write_seq_test.sv
`timescale 1ns/1ps
module page_write_seq_test;
    localparam int WCLK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_open = 1'b0;
    logic [8:0] wr_addr = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       scl_rise = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       wp = 1'b0;
    logic       busy, arr_we;
    logic [8:0] arr_addr;
    logic [7:0] arr_wdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [7:0] ref_mem [512];
    logic [7:0] dut_mem [512];

    page_write_seq #(.WRITE_CLKS(WCLK)) uut (
        .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .wr_addr(wr_addr),
        .rx_valid(rx_valid), .rx_data(rx_data), .scl_rise(scl_rise),
        .bus_start(bus_start), .bus_stop(bus_stop), .wp(wp),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) if (arr_we) dut_mem[arr_addr] <= arr_wdata;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < 512; i++) if (ref_mem[i] !== dut_mem[i]) m++;
        return m;
    endfunction

    function automatic bit expect_commit(input int n, input int endm, input bit wpv);
        return (n > 0) && (endm == 0) && !wpv;
    endfunction

    task automatic pulse_scl(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk) scl_rise = 1'b1;
            @(negedge clk) scl_rise = 1'b0;
        end
    endtask

    // endm: 0 stop after one edge, 1 stop with no edge, 2 stop after three edges, 3 START
    task automatic send_cmd(input int addr, input int n, input int endm, input bit wpv,
                            input bit poke, input string req);
        logic [7:0] img [16];
        bit         used [16];
        bit         com;
        int         cnt;
        int         sidx;
        bit         saw_we;
        for (int i = 0; i < 16; i++) used[i] = 1'b0;
        @(negedge clk) begin wr_open = 1'b1; wr_addr = addr[8:0]; end
        @(negedge clk) wr_open = 1'b0;
        for (int i = 0; i < n; i++) begin
            pulse_scl(9);
            sidx = ((addr % 16) + i) % 16;
            @(negedge clk) begin rx_valid = 1'b1; rx_data = 8'($urandom); end
            img[sidx] = rx_data;
            used[sidx] = 1'b1;
            @(negedge clk) rx_valid = 1'b0;
        end
        wp = wpv;
        if (endm == 0) pulse_scl(1);
        if (endm == 2) pulse_scl(3);
        if (endm == 3) begin
            @(negedge clk) bus_start = 1'b1;
            @(negedge clk) bus_start = 1'b0;
        end else begin
            @(negedge clk) bus_stop = 1'b1;
            @(negedge clk) bus_stop = 1'b0;
        end
        com = expect_commit(n, endm, wpv);
        if (com) begin
            for (int i = 0; i < 16; i++)
                if (used[i]) ref_mem[(addr & 9'h1F0) | i] = img[i];
            // R7 busy one cycle after the committing STOP
            chk(busy === 1'b1, "R7 busy after commit", int'(busy), 1);
            cnt = 1;
            if (arr_we) chk(arr_addr[3:0] == 4'd0, "R8 slot timing", int'(arr_addr[3:0]), 0);
            forever begin
                @(negedge clk);
                wr_open = 1'b0; rx_valid = 1'b0; bus_stop = 1'b0; scl_rise = 1'b0;
                bus_start = 1'b0;
                if (!busy) break;
                cnt++;
                if (arr_we)
                    chk(cnt <= 16 && int'(arr_addr[3:0]) == cnt - 1, "R8 slot timing",
                        int'(arr_addr[3:0]), cnt - 1);
                if (poke && cnt == 20) begin
                    // R9 traffic during the write cycle
                    wr_open = 1'b1; wr_addr = 9'h1FF; rx_valid = 1'b1; rx_data = 8'hA5;
                    bus_stop = 1'b1; scl_rise = 1'b1; wp = ~wp;
                end
            end
            chk(cnt == WCLK, poke ? "R9 R7 cycle length" : "R7 cycle length", cnt, WCLK);
            repeat (3) @(negedge clk);
            chk(busy === 1'b0, poke ? "R9 no restart" : "R7 idle after cycle", int'(busy), 0);
        end else begin
            saw_we = 1'b0;
            chk(busy === 1'b0, req, int'(busy), 0);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (arr_we || busy) saw_we = 1'b1;
            end
            chk(!saw_we, req, int'(saw_we), 0);
        end
        wp = 1'b0;
        chk(mem_mismatch() == 0, req, mem_mismatch(), 0);
    endtask

    initial begin
        int a, n, m, r;
        bit w, p;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) begin ref_mem[i] = 8'h00; dut_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && arr_we === 1'b0, "R1 reset state", int'({busy, arr_we}), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 after release", int'(busy), 0);

        // directed: byte write, page write, wrap past 16 bytes
        send_cmd(9'h035, 1, 0, 1'b0, 1'b0, "R2 R4 byte write");
        send_cmd(9'h120, 16, 0, 1'b0, 1'b0, "R4 full page");
        send_cmd(9'h0AE, 20, 0, 1'b0, 1'b0, "R3 wrap in page");
        send_cmd(9'h1F3, 3, 0, 1'b0, 1'b0, "R8 partial page");
        // discard cases
        send_cmd(9'h040, 0, 0, 1'b0, 1'b0, "R5 dummy write");
        send_cmd(9'h050, 4, 1, 1'b0, 1'b0, "R5 stop without edge");
        send_cmd(9'h060, 4, 2, 1'b0, 1'b0, "R5 late stop");
        send_cmd(9'h070, 4, 3, 1'b0, 1'b0, "R5 start aborts");
        send_cmd(9'h080, 5, 0, 1'b1, 1'b0, "R6 write protect");
        // traffic during busy
        send_cmd(9'h0C4, 6, 0, 1'b0, 1'b1, "R9 ignore while busy");

        // R1 reset during fill cancels commit
        @(negedge clk) begin wr_open = 1'b1; wr_addr = 9'h010; end
        @(negedge clk) wr_open = 1'b0;
        pulse_scl(9);
        @(negedge clk) begin rx_valid = 1'b1; rx_data = 8'h5A; end
        @(negedge clk) rx_valid = 1'b0;
        pulse_scl(1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        chk(busy === 1'b0, "R1 fill cancelled", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(mem_mismatch() == 0, "R1 fill cancelled mem", mem_mismatch(), 0);

        // R1 reset in the hold part of a write cycle
        @(negedge clk) begin wr_open = 1'b1; wr_addr = 9'h150; end
        @(negedge clk) wr_open = 1'b0;
        pulse_scl(9);
        @(negedge clk) begin rx_valid = 1'b1; rx_data = 8'hC3; end
        @(negedge clk) rx_valid = 1'b0;
        ref_mem[9'h150] = 8'hC3;
        pulse_scl(1);
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy === 1'b1, "R7 mid cycle", int'(busy), 1);
        rst_n = 1'b0;
        #1;
        chk(busy === 1'b0, "R1 reset drops busy", int'(busy), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(mem_mismatch() == 0, "R1 R8 mem after reset", mem_mismatch(), 0);

        // constrained random
        for (int it = 0; it < 30; it++) begin
            a = int'($urandom % 512);
            n = int'($urandom % 21);
            r = int'($urandom % 8);
            m = (r < 5) ? 0 : r - 4;
            w = ($urandom % 6) == 0;
            p = ($urandom % 4) == 0;
            send_cmd(a, n, m, w, p, "R3 R4 R5 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule